// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level translation table kept in external memory. A requester presents a virtual address together with an access kind (read or write) and a privilege mode (user or supervisor). The walker reads one directory word and then one table word through a single-word memory port. At each level it checks the presence, privilege and write-permission flags. It then returns either a physical address or a fault with a cause code and the level at which the fault was found.

The upper ten address bits select a directory word and the next ten select a word inside the table that the directory word points to. The low twelve bits pass through as the offset inside a 4 KB page. Every table holds 1024 words of 4 bytes, so it fills one page. The directory's frame number sits in a base register loaded through a configuration input. After a successful walk the walker writes the accessed flag back into each entry that lacked it, and it writes the dirty flag into the table entry on a write access. An entry is rewritten only if one of its flags changes. Only one translation is in flight at a time.

Top module: `ptw_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_valid` is 0.
- R2: The directory word is read at address `{base, 12'h000} + 4*va[31:22]`. The table word is read at `{dir_entry[31:12], 12'h000} + 4*va[21:12]`. A successful response has `rsp_fault`=0, `rsp_cause`=0 and `rsp_pa = {tbl_entry[31:12], va[11:0]}`. For example, the table entry 0x00003007 with offset 0x0AB gives 0x000030AB.
- R3: If bit 0 (present) of the directory entry is 0, the walk ends after that single read with `rsp_cause`=1 (absent) and `rsp_level`=0.
- R4: If bit 0 of the table entry is 0, the response has `rsp_cause`=1 and `rsp_level`=1.
- R5: A write access to an entry whose bit 1 (write enable) is 0 gives `rsp_cause`=2 at that entry's level. A read access to such an entry succeeds.
- R6: A user-mode access (`req_user`=1) to an entry whose bit 2 is 0 (supervisor only) gives `rsp_cause`=3 at that entry's level. A supervisor access to such an entry succeeds.
- R7: The checks have a fixed priority: absent, then privilege, then write permission. The directory level is checked before the table level.
- R8: After a successful walk, bit 5 (accessed) is 1 in both entries in memory, and on a write access bit 6 (dirty) is 1 in the table entry. Every memory write carries bit 5 set.
- R9: Each entry is written back at most once per walk and only when its flags change: the directory entry when bit 5 was 0, and the table entry when bit 5 was 0 or a write meets bit 6 = 0. A faulting walk writes nothing.
- R10: Every response returns the request's virtual address on `rsp_va`. A fault response has `rsp_fault`=1, a nonzero cause and `rsp_pa`=0.
- R11: `req_ready` is 1 only when no translation is in flight. A response stays valid and unchanged until `rsp_ready` accepts it. A memory request stays unchanged until `mem_ready` accepts it.
- R12: A cycle with `cfg_we`=1 loads `cfg_base` as the directory frame number used by later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the directory base register |
| cfg_base | input | 20 | Directory frame number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 absent, 2 write protect, 3 privilege |
| rsp_level | output | 1 | Fault level: 0 directory, 1 table |
| rsp_va | output | 32 | Virtual address of the request |
| rsp_pa | output | 32 | Physical address, 0 on fault |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write word, 0 = read word |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions check the port rules on every cycle. A held response and a stalled memory request must not change, the walker takes no request while busy, every write-back carries the accessed flag, and a fault carries no address while a success carries no cause. Several things only the bench scenarios can show. These are the correct entry addresses, the cause and level chosen for each flag combination and priority case, the number of reads and write-backs per walk, and the flag values left in memory. The bench also shows that a reloaded base redirects later walks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int WORD_LG = 2;
    localparam int PAD_W   = ADDR_W - IDX_W - WORD_LG;

    localparam int FL_PRES  = 0;
    localparam int FL_WEN   = 1;
    localparam int FL_USER  = 2;
    localparam int FL_ACC   = 5;
    localparam int FL_DIRTY = 6;

    typedef enum logic [1:0] {
        CS_NONE   = 2'd0,
        CS_ABSENT = 2'd1,
        CS_WPROT  = 2'd2,
        CS_PRIV   = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        S_IDLE, S_DRD, S_DWT, S_TRD, S_TWT, S_DWB, S_TWB, S_RSP
    } walk_st_e;

    typedef struct packed {
        walk_st_e            st;
        logic [FRAME_W-1:0]  base;
        logic [ADDR_W-1:0]   va;
        logic                wr;
        logic                usr;
        logic [ADDR_W-1:0]   dent;
        logic [ADDR_W-1:0]   tent;
        logic                fault;
        cause_e              cause;
        logic                level;
        logic [ADDR_W-1:0]   pa;
    } walk_regs_t;
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  logic   pres,
    input  logic   wen,
    input  logic   user_ok,
    input  logic   is_write,
    input  logic   is_user,
    output cause_e cause
);
    always_comb begin
        if (!pres)                   cause = CS_ABSENT;
        else if (is_user && !user_ok) cause = CS_PRIV;
        else if (is_write && !wen)    cause = CS_WPROT;
        else                          cause = CS_NONE;
    end
endmodule

// File: rtl/ptw_flag_upd.sv
module ptw_flag_upd
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  logic              mark_dirty,
    output logic [ADDR_W-1:0] updated,
    output logic              changed
);
    logic [ADDR_W-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        set_mask[FL_ACC] = 1'b1;
        set_mask[FL_DIRTY] = mark_dirty;
        updated = entry | set_mask;
        changed = (updated != entry);
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [FRAME_W-1:0]  cfg_base,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_va,
    input  logic                req_write,
    input  logic                req_user,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic                rsp_fault,
    output logic [1:0]          rsp_cause,
    output logic                rsp_level,
    output logic [ADDR_W-1:0]   rsp_va,
    output logic [ADDR_W-1:0]   rsp_pa,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ADDR_W-1:0]   mem_wdata,
    input  logic                mem_rvalid,
    input  logic [ADDR_W-1:0]   mem_rdata
);
    walk_regs_t r_q, r_d;

    cause_e            lvl_cause;
    logic [ADDR_W-1:0] dir_addr, tbl_addr;
    logic [ADDR_W-1:0] dir_new, tbl_new, tbl_src;
    logic              dir_chg, tbl_chg;

    assign dir_addr = {r_q.base, {OFF_W{1'b0}}}
                    + {{PAD_W{1'b0}}, r_q.va[ADDR_W-1 -: IDX_W], {WORD_LG{1'b0}}};
    assign tbl_addr = {r_q.dent[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                    + {{PAD_W{1'b0}}, r_q.va[OFF_W +: IDX_W], {WORD_LG{1'b0}}};
    assign tbl_src  = (r_q.st == S_TWT) ? mem_rdata : r_q.tent;

    ptw_perm u_perm (
        .pres     (mem_rdata[FL_PRES]),
        .wen      (mem_rdata[FL_WEN]),
        .user_ok  (mem_rdata[FL_USER]),
        .is_write (r_q.wr),
        .is_user  (r_q.usr),
        .cause    (lvl_cause)
    );

    ptw_flag_upd u_dir_upd (
        .entry      (r_q.dent),
        .mark_dirty (1'b0),
        .updated    (dir_new),
        .changed    (dir_chg)
    );

    ptw_flag_upd u_tbl_upd (
        .entry      (tbl_src),
        .mark_dirty (r_q.wr),
        .updated    (tbl_new),
        .changed    (tbl_chg)
    );

    always_comb begin
        r_d       = r_q;
        req_ready = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (cfg_we) r_d.base = cfg_base;
        case (r_q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.va    = req_va;
                    r_d.wr    = req_write;
                    r_d.usr   = req_user;
                    r_d.fault = 1'b0;
                    r_d.cause = CS_NONE;
                    r_d.level = 1'b0;
                    r_d.pa    = '0;
                    r_d.st    = S_DRD;
                end
            end
            S_DRD: begin
                mem_valid = 1'b1;
                mem_addr  = dir_addr;
                if (mem_ready) r_d.st = S_DWT;
            end
            S_DWT: begin
                if (mem_rvalid) begin
                    r_d.dent = mem_rdata;
                    if (lvl_cause != CS_NONE) begin
                        r_d.fault = 1'b1;
                        r_d.cause = lvl_cause;
                        r_d.level = 1'b0;
                        r_d.st    = S_RSP;
                    end else begin
                        r_d.st = S_TRD;
                    end
                end
            end
            S_TRD: begin
                mem_valid = 1'b1;
                mem_addr  = tbl_addr;
                if (mem_ready) r_d.st = S_TWT;
            end
            S_TWT: begin
                if (mem_rvalid) begin
                    r_d.tent = mem_rdata;
                    if (lvl_cause != CS_NONE) begin
                        r_d.fault = 1'b1;
                        r_d.cause = lvl_cause;
                        r_d.level = 1'b1;
                        r_d.st    = S_RSP;
                    end else begin
                        r_d.pa = {mem_rdata[ADDR_W-1:OFF_W], r_q.va[OFF_W-1:0]};
                        if (dir_chg)      r_d.st = S_DWB;
                        else if (tbl_chg) r_d.st = S_TWB;
                        else              r_d.st = S_RSP;
                    end
                end
            end
            S_DWB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dir_new;
                if (mem_ready) r_d.st = tbl_chg ? S_TWB : S_RSP;
            end
            S_TWB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = tbl_new;
                if (mem_ready) r_d.st = S_RSP;
            end
            S_RSP: begin
                if (rsp_ready) r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = (r_q.st == S_RSP);
    assign rsp_fault = r_q.fault;
    assign rsp_cause = r_q.cause;
    assign rsp_level = r_q.level;
    assign rsp_va    = r_q.va;
    assign rsp_pa    = r_q.pa;
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic [31:0] rsp_va,
    input logic [31:0] rsp_pa,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata
);
    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa)
                                    && $stable(rsp_cause) && $stable(rsp_va));
    // R11
    one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && !mem_valid);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
    // R8
    wb_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[5]);
    // R10
    fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_pa == 32'h0 && rsp_cause != 2'd0);
    // R2
    ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_cause == 2'd0);
endmodule

bind ptw_top ptw_top_chk u_chk (.*);

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [19:0] cfg_base = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_level;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_va, rsp_pa;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PER/2) clk = ~clk;

    ptw_top u_dut (.*);

    typedef struct packed {
        logic        fault;
        logic [1:0]  cause;
        logic        level;
        logic [31:0] va;
        logic [31:0] pa;
        logic [7:0]  tag;
    } exp_t;

    exp_t        sbq[$];
    logic [31:0] mem [bit [29:0]];
    int          total = 0, bad = 0, seen = 0, issued = 0;
    int          rd_cnt = 0, wr_cnt = 0, cyc = 0;
    bit          slow_rsp = 0, slow_mem = 0, finished = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a[31:2]) ? mem[a[31:2]] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && mem_valid && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[31:2]] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata  <= rd(mem_addr);
                mem_rvalid <= 1'b1;
                rd_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        mem_ready <= slow_mem ? cyc[0] : 1'b1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        rsp_ready = slow_rsp ? (cyc % 4 == 0) : 1'b1;
        if (rst_n && rsp_valid && rsp_ready) begin
            exp_t e;
            e = sbq.pop_front();
            chk(rsp_fault == e.fault && rsp_cause == e.cause && rsp_va == e.va
                && rsp_pa == e.pa && (!e.fault || rsp_level == e.level),
                $sformatf("R%0d response", e.tag),
                {rsp_fault, rsp_level, rsp_cause, rsp_pa[27:0]},
                {e.fault, e.level, e.cause, e.pa[27:0]});
            seen++;
        end
    end

    task automatic xlate(input logic [31:0] va, input bit wr, input bit usr,
                         input logic [19:0] base, input logic [7:0] tag);
        logic [31:0] da, ta, de, te;
        exp_t e;
        int exp_rd, exp_wr, r0, w0;
        da = {base, 12'h0} + {20'h0, va[31:22], 2'b00};
        de = rd(da);
        ta = {de[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        te = rd(ta);
        e = '0; e.va = va; e.tag = tag; exp_rd = 2; exp_wr = 0;
        if (!de[0])              begin e.fault = 1; e.cause = 1; e.level = 0; exp_rd = 1; end
        else if (usr && !de[2])  begin e.fault = 1; e.cause = 3; e.level = 0; exp_rd = 1; end
        else if (wr && !de[1])   begin e.fault = 1; e.cause = 2; e.level = 0; exp_rd = 1; end
        else if (!te[0])         begin e.fault = 1; e.cause = 1; e.level = 1; end
        else if (usr && !te[2])  begin e.fault = 1; e.cause = 3; e.level = 1; end
        else if (wr && !te[1])   begin e.fault = 1; e.cause = 2; e.level = 1; end
        else begin
            e.pa = {te[31:12], va[11:0]};
            exp_wr = (!de[5] ? 1 : 0) + ((!te[5] || (wr && !te[6])) ? 1 : 0);
        end
        sbq.push_back(e);
        issued++;
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1; req_va = va; req_write = wr; req_user = usr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 1'b0, "R11 busy", {31'h0, req_ready}, 32'h0);
        while (seen != issued) @(negedge clk);
        chk(rd_cnt - r0 == exp_rd, "R3 read count", rd_cnt - r0, exp_rd);
        chk(wr_cnt - w0 == exp_wr, "R9 write count", wr_cnt - w0, exp_wr);
        if (!e.fault) begin
            de = rd(da); te = rd(ta);
            chk(de[5] && te[5] && (!wr || te[6]), "R8 flags",
                {de[7:0], te[7:0]}, {8'h20, wr ? 8'h60 : 8'h20});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_valid, "R1 reset",
            {req_ready, rsp_valid, mem_valid}, 32'h4);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_valid, "R1 after reset",
            {req_ready, rsp_valid, mem_valid}, 32'h4);

        mem[32'h10000 >> 2] = 32'h00020007;            // dir 0 -> table 0x20
        mem[32'h10004 >> 2] = 32'h00000000;            // dir 1 absent
        mem[32'h10008 >> 2] = 32'h00021003;            // dir 2 supervisor
        mem[32'h2000C >> 2] = 32'h00003007;            // pte 3
        mem[32'h20010 >> 2] = 32'h00000006;            // pte 4 absent
        mem[32'h20014 >> 2] = 32'h00055005;            // pte 5 read-only user
        mem[32'h20018 >> 2] = 32'h00066003;            // pte 6 supervisor
        mem[32'h2001C >> 2] = 32'h00088001;            // pte 7 sup read-only
        mem[32'h21000 >> 2] = 32'h00077003;            // dir 2 pte 0
        mem[32'h30000 >> 2] = 32'h00025007;            // second dir
        mem[32'h25000 >> 2] = 32'h000AA007;

        @(negedge clk); cfg_we = 1; cfg_base = 20'h00010;
        @(negedge clk); cfg_we = 0;

        xlate(32'h000030AB, 0, 1, 20'h10, 2);   // R2 first walk
        xlate(32'h000030AB, 0, 1, 20'h10, 9);   // R9 no write-back
        xlate(32'h00003FFC, 1, 1, 20'h10, 8);   // R8 dirty set
        xlate(32'h00003000, 1, 0, 20'h10, 9);   // R9 no change
        xlate(32'h00400010, 0, 0, 20'h10, 3);   // R3 dir absent
        xlate(32'h00004000, 0, 0, 20'h10, 4);   // R4 table absent
        xlate(32'h00005123, 1, 1, 20'h10, 5);   // R5 write protect
        xlate(32'h00005123, 0, 1, 20'h10, 5);   // R5 read ok
        xlate(32'h00006456, 0, 1, 20'h10, 6);   // R6 user to sup page
        xlate(32'h00006456, 1, 0, 20'h10, 6);   // R6 supervisor ok
        xlate(32'h00800777, 0, 1, 20'h10, 6);   // R6 dir level priv
        slow_mem = 1;
        xlate(32'h00800777, 1, 0, 20'h10, 11);  // R11 memory stalls
        slow_mem = 0;
        xlate(32'h00007000, 1, 1, 20'h10, 7);   // R7 priv beats write
        xlate(32'h00007000, 1, 0, 20'h10, 7);   // R7 write protect
        slow_rsp = 1;
        xlate(32'h00400ABC, 1, 1, 20'h10, 10);  // R10 fault va, held rsp
        slow_rsp = 0;

        @(negedge clk); cfg_we = 1; cfg_base = 20'h00030;
        @(negedge clk); cfg_we = 0;
        xlate(32'h00000123, 0, 1, 20'h30, 12);  // R12 new base

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule